// File: doc/BRIEF.md
# Shaped-Index Helper Encoder

This block turns one key bit into a helper index over a group of 2^W signed response values. The values arrive one per accepted cycle. Each value comes with a few random bits, and those bits decide whether the value may take part in the selection. The values that may take part are the survivors. Among the survivors the encoder returns the position of the largest value when the key bit is 1 and of the smallest value when it is 0. The later recovery step reads the sign of the value at that position, so the decoder does not change. Skipping candidates at random flattens the spread of the index values, so each index says less about the response source. The extreme-value choice that gives the code its strength is kept.

A programmable skip level L selects m = L+1 random bits per candidate. A candidate survives only when all m of its low random bits are 1, so the skip probability is 1 - 2^-m: 1/2, 3/4, 7/8 or 15/16. If no candidate of a group survives, the encoder uses a plain search over the whole group instead. It marks that result as a fallback and sets a status flag that stays set until reset.

The controller is a three-state machine. IDLE waits for a start pulse. In IDLE, start moves the machine to SCAN and latches the key bit and the skip level. SCAN consumes exactly 2^W sample beats, and idle cycles between beats are allowed. The beat that carries the last sample moves the machine to EMIT. EMIT drives the result strobe for one cycle. From EMIT the machine goes back to IDLE, or straight to SCAN if start is high in that cycle.

Top module: `sds_encoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, idx_valid_o, busy_o and all_skipped_o are 0.
- R2: A start pulse accepted in IDLE or EMIT begins a group. The group takes exactly 2^W beats of smp_valid_i. idx_valid_o is high for exactly one cycle, in the cycle right after the edge that takes the last beat. busy_o is high while the group is being collected.
- R3: With skip level L (0..3), the candidate at position i survives only if bits [L:0] of its rnd_i are all 1. A candidate that does not survive is never chosen unless no candidate survives.
- R4: When the latched key bit is 1, idx_o is the position (0 to 2^W-1, in arrival order) of the largest surviving value.
- R5: When the latched key bit is 0, idx_o is the position of the smallest surviving value.
- R6: When several candidates tie for the chosen extreme, the lowest position wins.
- R7: If no candidate in a group survives, idx_o comes from the same max/min search over all 2^W values, and fallback_o is 1 with the strobe. fallback_o is 0 for a group that has at least one survivor.
- R8: all_skipped_o becomes 1 in the cycle after a fallback result and stays 1 until reset.
- R9: Sample beats while no group is open, and start pulses during SCAN, have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a group (taken in IDLE or EMIT) |
| key_i | input | 1 | Key bit, latched on start |
| level_i | input | 2 | Skip level L, m = L+1 random bits per candidate |
| smp_valid_i | input | 1 | A sample beat is present |
| smp_i | input | DW (8) | Signed response value |
| rnd_i | input | RW (4) | Random bits for this candidate |
| busy_o | output | 1 | Group is being collected |
| idx_valid_o | output | 1 | One-cycle result strobe |
| idx_o | output | W (4) | Selected position |
| fallback_o | output | 1 | Result came from the unmasked search |
| all_skipped_o | output | 1 | Sticky flag: a fallback has happened |

## Verification
The result strobe of one group and the start of the next can fall in the same EMIT cycle. The bench raises start in the strobe cycle of a fallback group and then streams the next group with no idle cycle between them. It expects the first result and its fallback flag to be intact, and the second group's index to be computed only from its own samples and masks. The last beat of a group can also be its only survivor, so the final comparison and the decision between masked and fallback results fall on the same edge. The bench covers this with masks in which only position 15 survives, and compares the result with an independent model held in the scoreboard queue.

// File: rtl/sds_pkg.sv
package sds_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_EMIT = 2'd2
    } sds_state_e;
endpackage

// File: rtl/sds_mask.sv
module sds_mask #(
    parameter int RW = 4,
    localparam int LW = (RW > 1) ? $clog2(RW) : 1
) (
    input  logic [RW-1:0] rnd_i,
    input  logic [LW-1:0] level_i,
    output logic          keep_o
);
    // Candidate survives when every random bit in [level:0] is 1.
    always_comb begin
        keep_o = 1'b1;
        for (int k = 0; k < RW; k++) begin
            if (k <= int'(level_i)) keep_o = keep_o & rnd_i[k];
        end
    end
endmodule

// File: rtl/sds_tracker.sv
module sds_tracker #(
    parameter int W  = 4,
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 take_i,
    input  logic                 sel_max_i,
    input  logic [W-1:0]         idx_i,
    input  logic signed [DW-1:0] val_i,
    output logic [W-1:0]         best_idx_o,
    output logic                 found_o
);
    logic signed [DW-1:0] best_val_q;
    logic                 beats;

    // Strict compare: an equal later value never replaces, so ties keep the lowest index.
    always_comb begin
        beats = sel_max_i ? (val_i > best_val_q) : (val_i < best_val_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            found_o    <= 1'b0;
            best_idx_o <= '0;
            best_val_q <= '0;
        end else if (clear_i) begin
            found_o <= 1'b0;
        end else if (take_i && (!found_o || beats)) begin
            found_o    <= 1'b1;
            best_idx_o <= idx_i;
            best_val_q <= val_i;
        end
    end

    p_found_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (found_o && !clear_i) |=> found_o);
    p_first_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !clear_i) |=> found_o);
endmodule

// File: rtl/sds_encoder.sv
module sds_encoder
    import sds_pkg::*;
#(
    parameter int W  = 4,
    parameter int DW = 8,
    parameter int RW = 4,
    localparam int LW = (RW > 1) ? $clog2(RW) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 key_i,
    input  logic [LW-1:0]        level_i,
    input  logic                 smp_valid_i,
    input  logic signed [DW-1:0] smp_i,
    input  logic [RW-1:0]        rnd_i,
    output logic                 busy_o,
    output logic                 idx_valid_o,
    output logic [W-1:0]         idx_o,
    output logic                 fallback_o,
    output logic                 all_skipped_o
);
    localparam logic [W-1:0] LAST_IDX = {W{1'b1}};

    sds_state_e    state_q, state_d;
    logic [W-1:0]  cnt_q;
    logic          key_q;
    logic [LW-1:0] lvl_q;
    logic          start_acc, last_beat, take, keep;
    logic [W-1:0]  m_idx, a_idx;
    logic          m_found, a_found;

    assign start_acc = start_i && (state_q == ST_IDLE || state_q == ST_EMIT);
    assign take      = (state_q == ST_SCAN) && smp_valid_i;
    assign last_beat = take && (cnt_q == LAST_IDX);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_acc) state_d = ST_SCAN;
            ST_SCAN: if (last_beat) state_d = ST_EMIT;
            ST_EMIT: state_d = start_acc ? ST_SCAN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            cnt_q         <= '0;
            key_q         <= 1'b0;
            lvl_q         <= '0;
            all_skipped_o <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_acc) begin
                cnt_q <= '0;
                key_q <= key_i;
                lvl_q <= level_i;
            end else if (take) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == ST_EMIT && !m_found) all_skipped_o <= 1'b1;
        end
    end

    sds_mask #(.RW(RW)) u_mask (
        .rnd_i   (rnd_i),
        .level_i (lvl_q),
        .keep_o  (keep)
    );

    sds_tracker #(.W(W), .DW(DW)) u_masked (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_acc),
        .take_i     (take && keep),
        .sel_max_i  (key_q),
        .idx_i      (cnt_q),
        .val_i      (smp_i),
        .best_idx_o (m_idx),
        .found_o    (m_found)
    );

    sds_tracker #(.W(W), .DW(DW)) u_whole (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_acc),
        .take_i     (take),
        .sel_max_i  (key_q),
        .idx_i      (cnt_q),
        .val_i      (smp_i),
        .best_idx_o (a_idx),
        .found_o    (a_found)
    );

    always_comb begin
        busy_o      = (state_q == ST_SCAN);
        idx_valid_o = (state_q == ST_EMIT);
        fallback_o  = (state_q == ST_EMIT) && !m_found;
        idx_o       = m_found ? m_idx : a_idx;
    end

    p_strobe_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> idx_valid_o);
    p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_valid_o |=> !idx_valid_o);
    p_whole_seen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        idx_valid_o |-> a_found);
    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        all_skipped_o |=> all_skipped_o);
    p_fallback_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fallback_o |=> all_skipped_o);
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last_beat) |=> busy_o);
endmodule

// File: tb/test_sds_encoder.sv
module test_sds_encoder;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0, key_i = 1'b0, smp_valid_i = 1'b0;
    logic [1:0]        level_i = '0;
    logic signed [7:0] smp_i = '0;
    logic [3:0]        rnd_i = '0;
    logic              busy_o, idx_valid_o, fallback_o, all_skipped_o;
    logic [3:0]        idx_o;

    int n_chk = 0, n_fail = 0;
    logic signed [7:0] gv [16];
    logic [3:0]        gr [16];
    int                q_idx [$];
    bit                q_fb  [$];
    string             q_req [$];
    int unsigned       lcg = 32'h1234_5678;

    always #4 clk = ~clk;

    sds_encoder i_sds_encoder (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
        .level_i(level_i), .smp_valid_i(smp_valid_i), .smp_i(smp_i),
        .rnd_i(rnd_i), .busy_o(busy_o), .idx_valid_o(idx_valid_o),
        .idx_o(idx_o), .fallback_o(fallback_o), .all_skipped_o(all_skipped_o)
    );

    function automatic int unsigned nxt();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg >> 8;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference: survivors need bits [lvl:0] all ones; strict compare keeps lowest on ties.
    task automatic model(input bit key, input int lvl, input string req);
        int  bi = -1, ai = -1;
        bit  fb;
        logic [3:0] msk = 4'((1 << (lvl + 1)) - 1);
        for (int i = 0; i < 16; i++) begin
            if (ai < 0 || (key ? gv[i] > gv[ai] : gv[i] < gv[ai])) ai = i;
            if ((gr[i] & msk) == msk)
                if (bi < 0 || (key ? gv[i] > gv[bi] : gv[i] < gv[bi])) bi = i;
        end
        fb = (bi < 0);
        q_idx.push_back(fb ? ai : bi);
        q_fb.push_back(fb);
        q_req.push_back(req);
    endtask

    // Driver: ends at the falling edge of the strobe cycle.
    task automatic run_group(input bit key, input int lvl, input bit gaps,
                             input bit b2b, input bit intrude, input string req);
        model(key, lvl, req);
        if (!b2b) @(negedge clk);
        start_i = 1'b1; key_i = key; level_i = 2'(lvl);
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 16; i++) begin
            if (gaps && (i % 3 == 1)) begin
                smp_valid_i = 1'b0; smp_i = 8'sd127; rnd_i = 4'hF;
                @(negedge clk);
            end
            smp_valid_i = 1'b1; smp_i = gv[i]; rnd_i = gr[i];
            if (intrude && i == 5) begin start_i = 1'b1; key_i = ~key; level_i = 2'd0; end
            @(negedge clk);
            start_i = 1'b0;
        end
        smp_valid_i = 1'b0;
    endtask

    task automatic fill_rand(input logic [3:0] rfix, input bit use_fix);
        for (int i = 0; i < 16; i++) begin
            gv[i] = 8'(nxt());
            gr[i] = use_fix ? rfix : 4'(nxt());
        end
    endtask

    // Monitor: pops one expected item per strobe.
    always @(negedge clk) begin
        if (rst_n && idx_valid_o) begin
            if (q_idx.size() == 0) begin
                check("R2 unexpected strobe", 1, 0);
            end else begin
                string r = q_req.pop_front();
                check(r, int'(idx_o), q_idx.pop_front());
                check({r, " R7 fallback"}, int'(fallback_o), int'(q_fb.pop_front()));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 strobe in reset", int'(idx_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 strobe", int'(idx_valid_o), 0);
        check("R1 busy", int'(busy_o), 0);
        check("R1 sticky", int'(all_skipped_o), 0);

        // R9: beats with no open group
        for (int i = 0; i < 5; i++) begin
            smp_valid_i = 1'b1; smp_i = -8'sd128; rnd_i = 4'hF;
            @(negedge clk);
            check("R9 idle beat busy", int'(busy_o), 0);
            check("R9 idle beat strobe", int'(idx_valid_o), 0);
        end
        smp_valid_i = 1'b0;

        // R4/R5 all survive
        fill_rand(4'hF, 1'b1);
        run_group(1'b1, 0, 1'b0, 1'b0, 1'b0, "R4 max all survive");
        run_group(1'b0, 0, 1'b1, 1'b0, 1'b0, "R5 min all survive gaps R2");

        // R6 ties
        for (int i = 0; i < 16; i++) begin gv[i] = 8'sd5; gr[i] = 4'hF; end
        gv[3] = 8'sd100; gv[9] = 8'sd100; gv[4] = -8'sd90; gv[12] = -8'sd90;
        run_group(1'b1, 0, 1'b0, 1'b0, 1'b0, "R6 max tie lowest");
        run_group(1'b0, 0, 1'b0, 1'b0, 1'b0, "R6 min tie lowest");

        // R3 level decides survivor
        for (int i = 0; i < 16; i++) begin gv[i] = 8'(i); gr[i] = 4'hF; end
        gv[2] = 8'sd120; gr[2] = 4'b0011;
        gv[7] = 8'sd110; gr[7] = 4'b0111;
        run_group(1'b1, 1, 1'b0, 1'b0, 1'b0, "R3 level1 keeps pos2");
        run_group(1'b1, 2, 1'b0, 1'b0, 1'b0, "R3 level2 skips pos2");
        run_group(1'b1, 3, 1'b0, 1'b0, 1'b0, "R3 level3 skips pos2 pos7");

        // R9 start during scan
        fill_rand(4'h0, 1'b0);
        run_group(1'b1, 1, 1'b0, 1'b0, 1'b1, "R9 start in scan ignored");

        // Only the last beat survives
        fill_rand(4'h0, 1'b1);
        gr[15] = 4'hF;
        run_group(1'b0, 3, 1'b0, 1'b0, 1'b0, "R3 last beat sole survivor");
        check("R8 sticky before fallback", int'(all_skipped_o), 0);

        // R7 fallback followed back-to-back by the next group
        fill_rand(4'h0, 1'b1);
        gv[6] = 8'sd127; gv[11] = -8'sd128;
        run_group(1'b1, 0, 1'b0, 1'b0, 1'b0, "R7 fallback max");
        fill_rand(4'hF, 1'b0);
        run_group(1'b0, 2, 1'b0, 1'b1, 1'b0, "R2 back-to-back after fallback");
        check("R8 sticky set", int'(all_skipped_o), 1);

        for (int g = 0; g < 24; g++) begin
            fill_rand(4'h0, 1'b0);
            run_group(g[0], g % 4, g[1], 1'b0, 1'b0, "R4 R5 random groups");
        end
        @(negedge clk);
        check("R8 sticky holds", int'(all_skipped_o), 1);
        check("R2 all results seen", q_idx.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule